// File: doc/BRIEF.md
# Multicart PRG and CHR Address Composer

This combinational block sits between a banked base memory controller and the ROM and CHR memories of a multicart. It builds the final 22-bit PRG-ROM address and the 20-bit CHR address. Each address is made from four sources: the outer configuration fields, the base controller's banked address bits, and the raw CPU and PPU address lines. It also decides which CPU A13/A14 values the base controller sees. It also decides whether a CPU read of the upper program window returns ROM data or a 2-bit jumper value.

Outer bits select a 128 KiB or 256 KiB inner bank for PRG and for CHR. Three fixed PRG modes mimic a single 16 KiB or 32 KiB bank: the base controller is shown CPU A13/A14 held low, and the raw CPU lines take over the low bank bits. A fixed CHR mode replaces the base controller's CHR banking with an 8 KiB bank number taken from a 4-bit field. The registers that hold these fields are outside the block.

Top module: `mc_addr_compose`

## Requirements
- R1: prg_addr_o[12:0] always equals cpu_addr_i[12:0]. prg_addr_o bits 21, 20, 19 and 18 equal outer_cfg_i bits 5, 4, 2 and 1 respectively.
- R2: prg_addr_o[17] equals outer_cfg_i[0] when outer_cfg_i[6] is 1. Otherwise it equals base_prg_bank_i[4].
- R3: With prg_mode_i = 0, base_cpu_a13_o/base_cpu_a14_o follow cpu_addr_i[13]/cpu_addr_i[14]. In the same mode, prg_addr_o[13] = base_prg_bank_i[0] and prg_addr_o[14] = base_prg_bank_i[1].
- R4: With prg_mode_i = 1 or 2, base_cpu_a13_o and base_cpu_a14_o are 0. In these modes prg_addr_o[13] = cpu_addr_i[13] and prg_addr_o[14] = base_prg_bank_i[1].
- R5: With prg_mode_i = 3, both base lines are 0, prg_addr_o[13] = cpu_addr_i[13] and prg_addr_o[14] = cpu_addr_i[14].
- R6: prg_addr_o[16:15] always equals base_prg_bank_i[3:2].
- R7: chr_addr_o[17] equals outer_cfg_i[3] when outer_cfg_i[7] is 1. Otherwise it equals base_chr_bank_i[7], in either CHR mode.
- R8: chr_addr_o[18] equals outer_cfg_i[5] and chr_addr_o[19] equals outer_cfg_i[4]. This is the reverse of the PRG order.
- R9: With chr_fixed_i = 0, chr_addr_o[9:0] = ppu_addr_i[9:0] and chr_addr_o[16:10] = base_chr_bank_i[6:0].
- R10: With chr_fixed_i = 1, chr_addr_o[12:0] = ppu_addr_i[12:0] and chr_addr_o[16:13] = chr_bank_i. base_chr_bank_i[6:0] then has no effect.
- R11: When jumper_sel_i and cpu_rom_rd_i are both 1, cpu_data_o = {6'b0, jumper_i}. Otherwise cpu_data_o = rom_data_i.
- R12: Every output settles from its inputs with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| outer_cfg_i | input | 8 | Outer bank and inner-size control field |
| prg_mode_i | input | 2 | PRG mode: 0 banked, 1/2 fixed 16 KiB, 3 fixed 32 KiB |
| chr_fixed_i | input | 1 | 1 selects fixed 8 KiB CHR mode |
| chr_bank_i | input | 4 | 8 KiB CHR bank number for fixed CHR mode |
| jumper_sel_i | input | 1 | 1 returns jumper value on upper-window reads |
| cpu_addr_i | input | 15 | CPU A14..A0 |
| cpu_rom_rd_i | input | 1 | CPU read cycle in the upper program window |
| base_prg_bank_i | input | 5 | Base controller PRG A17..A13 |
| base_chr_bank_i | input | 8 | Base controller CHR A17..A10 |
| ppu_addr_i | input | 13 | PPU A12..A0 |
| rom_data_i | input | 8 | PRG-ROM read data |
| jumper_i | input | 2 | Jumper pad value |
| base_cpu_a13_o | output | 1 | CPU A13 as seen by base controller |
| base_cpu_a14_o | output | 1 | CPU A14 as seen by base controller |
| prg_addr_o | output | 22 | Final PRG-ROM address |
| chr_addr_o | output | 20 | Final CHR address |
| cpu_data_o | output | 8 | Data returned to the CPU |

## Verification
The bound checker tests several rules on every input change. These are the pass-through of PRG low bits, the mapping of the outer PRG and reversed CHR bits, the low base lines in fixed PRG modes, the CPU A14 takeover in the 32 KiB mode, the fixed CHR bank field, and the jumper substitution. Other behaviour needs the bench's sweep, which covers every outer field value against every PRG and CHR mode. That sweep shows the inner-size selection for A17, the split in the 16 KiB modes between raw CPU A13 and base controller A14, and that base CHR bits have no effect in fixed CHR mode. Same-cycle settling is shown by sampling with no clock edge between stimulus and check.

// File: rtl/mc_addr_pkg.sv
package mc_addr_pkg;
  localparam int unsigned PRG_W      = 22;
  localparam int unsigned CHR_W      = 20;
  localparam int unsigned CPU_W      = 15;
  localparam int unsigned PPU_W      = 13;
  localparam int unsigned BASE_PRG_W = 5;   // A17..A13
  localparam int unsigned BASE_CHR_W = 8;   // A17..A10
  localparam int unsigned FIX_CHR_W  = 4;   // A16..A13
  localparam int unsigned DATA_W     = 8;
  localparam int unsigned JMP_W      = 2;
  localparam int unsigned PAGE_LSB   = 13;
  localparam int unsigned CHR_OUT_W  = 2;   // CHR A19..A18 from outer field

  typedef enum logic [1:0] {
    PM_BANKED  = 2'd0,
    PM_FIX16_A = 2'd1,
    PM_FIX16_B = 2'd2,
    PM_FIX32   = 2'd3
  } prg_mode_e;

  typedef struct packed {
    logic chr_a17_own;  // 7
    logic prg_a17_own;  // 6
    logic hi_a;         // 5: PRG A21, CHR A18
    logic hi_b;         // 4: PRG A20, CHR A19
    logic chr_a17;      // 3
    logic prg_a19;      // 2
    logic prg_a18;      // 1
    logic prg_a17;      // 0
  } outer_cfg_t;
endpackage

// File: rtl/mc_prg_compose.sv
module mc_prg_compose
  import mc_addr_pkg::*;
(
  input  outer_cfg_t            outer_i,
  input  prg_mode_e             mode_i,
  input  logic [CPU_W-1:0]      cpu_addr_i,
  input  logic [BASE_PRG_W-1:0] base_bank_i,
  output logic                  base_a13_o,
  output logic                  base_a14_o,
  output logic [PRG_W-1:0]      prg_addr_o
);
  logic fixed_mode, wide_mode;

  assign fixed_mode = (mode_i != PM_BANKED);
  assign wide_mode  = (mode_i == PM_FIX32);

  // base controller sees page 0 of the window in fixed modes
  assign base_a13_o = fixed_mode ? 1'b0 : cpu_addr_i[13];
  assign base_a14_o = fixed_mode ? 1'b0 : cpu_addr_i[14];

  always_comb begin
    prg_addr_o                 = '0;
    prg_addr_o[PAGE_LSB-1:0]   = cpu_addr_i[PAGE_LSB-1:0];
    prg_addr_o[13]             = fixed_mode ? cpu_addr_i[13] : base_bank_i[0];
    prg_addr_o[14]             = wide_mode  ? cpu_addr_i[14] : base_bank_i[1];
    prg_addr_o[16:15]          = base_bank_i[3:2];
    prg_addr_o[17]             = outer_i.prg_a17_own ? outer_i.prg_a17 : base_bank_i[4];
    prg_addr_o[18]             = outer_i.prg_a18;
    prg_addr_o[19]             = outer_i.prg_a19;
    prg_addr_o[20]             = outer_i.hi_b;
    prg_addr_o[21]             = outer_i.hi_a;
  end
endmodule

// File: rtl/mc_chr_compose.sv
module mc_chr_compose
  import mc_addr_pkg::*;
(
  input  outer_cfg_t            outer_i,
  input  logic                  fixed_i,
  input  logic [FIX_CHR_W-1:0]  fix_bank_i,
  input  logic [BASE_CHR_W-1:0] base_bank_i,
  input  logic [PPU_W-1:0]      ppu_addr_i,
  output logic [CHR_W-1:0]      chr_addr_o
);
  localparam int unsigned INNER_W = 17;  // A16..A0 inner span
  logic [INNER_W-1:0]   inner_banked, inner_fixed;
  logic [CHR_OUT_W-1:0] outer_src;

  assign inner_banked = {base_bank_i[BASE_CHR_W-2:0], ppu_addr_i[9:0]};
  assign inner_fixed  = {fix_bank_i, ppu_addr_i};
  assign outer_src    = {outer_i.hi_a, outer_i.hi_b};

  assign chr_addr_o[INNER_W-1:0] = fixed_i ? inner_fixed : inner_banked;
  assign chr_addr_o[17] = outer_i.chr_a17_own ? outer_i.chr_a17 : base_bank_i[BASE_CHR_W-1];

  // outer CHR bits land in reverse order relative to PRG
  for (genvar g = 0; g < CHR_OUT_W; g++) begin : g_chr_hi
    assign chr_addr_o[18+g] = outer_src[CHR_OUT_W-1-g];
  end
endmodule

// File: rtl/mc_data_select.sv
module mc_data_select
  import mc_addr_pkg::*;
(
  input  logic              sel_i,
  input  logic              rd_i,
  input  logic [DATA_W-1:0] rom_i,
  input  logic [JMP_W-1:0]  jumper_i,
  output logic [DATA_W-1:0] data_o
);
  logic take_jmp;
  assign take_jmp = sel_i & rd_i;

  for (genvar g = 0; g < DATA_W; g++) begin : g_bit
    if (g < JMP_W) begin : g_jmp
      assign data_o[g] = take_jmp ? jumper_i[g] : rom_i[g];
    end else begin : g_pad
      assign data_o[g] = take_jmp ? 1'b0 : rom_i[g];
    end
  end
endmodule

// File: rtl/mc_addr_compose.sv
module mc_addr_compose
  import mc_addr_pkg::*;
(
  input  logic [7:0]            outer_cfg_i,
  input  logic [1:0]            prg_mode_i,
  input  logic                  chr_fixed_i,
  input  logic [FIX_CHR_W-1:0]  chr_bank_i,
  input  logic                  jumper_sel_i,
  input  logic [CPU_W-1:0]      cpu_addr_i,
  input  logic                  cpu_rom_rd_i,
  input  logic [BASE_PRG_W-1:0] base_prg_bank_i,
  input  logic [BASE_CHR_W-1:0] base_chr_bank_i,
  input  logic [PPU_W-1:0]      ppu_addr_i,
  input  logic [DATA_W-1:0]     rom_data_i,
  input  logic [JMP_W-1:0]      jumper_i,
  output logic                  base_cpu_a13_o,
  output logic                  base_cpu_a14_o,
  output logic [PRG_W-1:0]      prg_addr_o,
  output logic [CHR_W-1:0]      chr_addr_o,
  output logic [DATA_W-1:0]     cpu_data_o
);
  outer_cfg_t outer;
  prg_mode_e  pmode;

  assign outer = outer_cfg_t'(outer_cfg_i);
  assign pmode = prg_mode_e'(prg_mode_i);

  mc_prg_compose u_prg (
    .outer_i     (outer),
    .mode_i      (pmode),
    .cpu_addr_i  (cpu_addr_i),
    .base_bank_i (base_prg_bank_i),
    .base_a13_o  (base_cpu_a13_o),
    .base_a14_o  (base_cpu_a14_o),
    .prg_addr_o  (prg_addr_o)
  );

  mc_chr_compose u_chr (
    .outer_i     (outer),
    .fixed_i     (chr_fixed_i),
    .fix_bank_i  (chr_bank_i),
    .base_bank_i (base_chr_bank_i),
    .ppu_addr_i  (ppu_addr_i),
    .chr_addr_o  (chr_addr_o)
  );

  mc_data_select u_data (
    .sel_i    (jumper_sel_i),
    .rd_i     (cpu_rom_rd_i),
    .rom_i    (rom_data_i),
    .jumper_i (jumper_i),
    .data_o   (cpu_data_o)
  );
endmodule

// File: rtl/mc_addr_compose_chk.sv
module mc_addr_compose_chk
  import mc_addr_pkg::*;
(
  input logic [7:0]            outer_cfg_i,
  input logic [1:0]            prg_mode_i,
  input logic                  chr_fixed_i,
  input logic [FIX_CHR_W-1:0]  chr_bank_i,
  input logic                  jumper_sel_i,
  input logic [CPU_W-1:0]      cpu_addr_i,
  input logic                  cpu_rom_rd_i,
  input logic [PPU_W-1:0]      ppu_addr_i,
  input logic [JMP_W-1:0]      jumper_i,
  input logic                  base_cpu_a13_o,
  input logic                  base_cpu_a14_o,
  input logic [PRG_W-1:0]      prg_addr_o,
  input logic [CHR_W-1:0]      chr_addr_o,
  input logic [DATA_W-1:0]     cpu_data_o
);
  logic known;
  assign known = !$isunknown({outer_cfg_i, prg_mode_i, chr_fixed_i, chr_bank_i,
                              jumper_sel_i, cpu_addr_i, cpu_rom_rd_i, ppu_addr_i, jumper_i});

  always_comb begin
    if (known) begin
      assert_prg_page_R1: assert (prg_addr_o[12:0] == cpu_addr_i[12:0]);
      assert_prg_outer_R1: assert ({prg_addr_o[21], prg_addr_o[20], prg_addr_o[19], prg_addr_o[18]}
                                   == {outer_cfg_i[5], outer_cfg_i[4], outer_cfg_i[2], outer_cfg_i[1]});
      if (prg_mode_i != 2'd0) begin
        assert_base_low_R4: assert (!base_cpu_a13_o && !base_cpu_a14_o && prg_addr_o[13] == cpu_addr_i[13]);
      end
      if (prg_mode_i == 2'd3) begin
        assert_wide_a14_R5: assert (prg_addr_o[14] == cpu_addr_i[14]);
      end
      assert_chr_rev_R8: assert (chr_addr_o[19] == outer_cfg_i[4] && chr_addr_o[18] == outer_cfg_i[5]);
      if (chr_fixed_i) begin
        assert_chr_fixed_R10: assert (chr_addr_o[16:13] == chr_bank_i && chr_addr_o[12:0] == ppu_addr_i);
      end
      if (jumper_sel_i && cpu_rom_rd_i) begin
        assert_jumper_R11: assert (cpu_data_o == {{(DATA_W-JMP_W){1'b0}}, jumper_i});
      end
    end
  end
endmodule

bind mc_addr_compose mc_addr_compose_chk chk_i (.*);

// File: tb/mc_addr_compose_tb_top.sv
module mc_addr_compose_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic [7:0]  outer_cfg;
  logic [1:0]  prg_mode;
  logic        chr_fixed;
  logic [3:0]  chr_bank;
  logic        jumper_sel;
  logic [14:0] cpu_addr;
  logic        cpu_rom_rd;
  logic [4:0]  base_prg;
  logic [7:0]  base_chr;
  logic [12:0] ppu_addr;
  logic [7:0]  rom_data;
  logic [1:0]  jumper;
  logic        base_a13, base_a14;
  logic [21:0] prg_addr;
  logic [19:0] chr_addr;
  logic [7:0]  cpu_data;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mc_addr_compose dut_i (
    .outer_cfg_i(outer_cfg), .prg_mode_i(prg_mode), .chr_fixed_i(chr_fixed),
    .chr_bank_i(chr_bank), .jumper_sel_i(jumper_sel), .cpu_addr_i(cpu_addr),
    .cpu_rom_rd_i(cpu_rom_rd), .base_prg_bank_i(base_prg), .base_chr_bank_i(base_chr),
    .ppu_addr_i(ppu_addr), .rom_data_i(rom_data), .jumper_i(jumper),
    .base_cpu_a13_o(base_a13), .base_cpu_a14_o(base_a14), .prg_addr_o(prg_addr),
    .chr_addr_o(chr_addr), .cpu_data_o(cpu_data)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic int bitv(input int v, input int b);
    return (v >> b) & 1;
  endfunction

  task automatic check_all();
    int o = outer_cfg, exp_a17, exp_a13, exp_a14, exp_lines, exp_low, exp_data;
    string t34;
    chk("R1 prg page", prg_addr % 8192, cpu_addr % 8192);
    chk("R1 prg outer", prg_addr / 262144,
        bitv(o,1) + 2*bitv(o,2) + 4*bitv(o,4) + 8*bitv(o,5));
    exp_a17 = bitv(o,6) ? bitv(o,0) : bitv(base_prg,4);
    chk("R2 prg a17", bitv(prg_addr,17), exp_a17);
    chk("R6 prg a16:a15", (prg_addr / 32768) % 4, (base_prg / 4) % 4);
    if (prg_mode == 0) begin
      t34 = "R3"; exp_a13 = bitv(base_prg,0); exp_a14 = bitv(base_prg,1);
      exp_lines = bitv(cpu_addr,13) + 2*bitv(cpu_addr,14);
    end else if (prg_mode == 3) begin
      t34 = "R5"; exp_a13 = bitv(cpu_addr,13); exp_a14 = bitv(cpu_addr,14); exp_lines = 0;
    end else begin
      t34 = "R4"; exp_a13 = bitv(cpu_addr,13); exp_a14 = bitv(base_prg,1); exp_lines = 0;
    end
    chk({t34, " prg a14:a13"}, bitv(prg_addr,13) + 2*bitv(prg_addr,14), exp_a13 + 2*exp_a14);
    chk({t34, " base lines"}, base_a13 + 2*base_a14, exp_lines);
    chk("R7 chr a17", bitv(chr_addr,17), bitv(o,7) ? bitv(o,3) : bitv(base_chr,7));
    chk("R8 chr a19:a18", chr_addr / 262144, bitv(o,5) + 2*bitv(o,4));
    if (chr_fixed) begin
      exp_low = chr_bank * 8192 + ppu_addr;
      chk("R10 chr inner", chr_addr % 131072, exp_low);
    end else begin
      exp_low = (base_chr % 128) * 1024 + (ppu_addr % 1024);
      chk("R9 chr inner", chr_addr % 131072, exp_low);
    end
    exp_data = (jumper_sel && cpu_rom_rd) ? jumper : rom_data;
    chk("R11 cpu data", cpu_data, exp_data);
  endtask

  initial begin
    outer_cfg = 0; prg_mode = 0; chr_fixed = 0; chr_bank = 0; jumper_sel = 0;
    cpu_addr = 0; cpu_rom_rd = 0; base_prg = 0; base_chr = 0; ppu_addr = 0;
    rom_data = 0; jumper = 0;
    #1;
    chk("R1 idle prg", prg_addr, 0);
    chk("R8 idle chr", chr_addr, 0);
    chk("R11 idle data", cpu_data, 0);
    for (int it = 0; it < 4096; it++) begin
      @(negedge clk);
      outer_cfg  = it[7:0];
      prg_mode   = it[9:8];
      chr_fixed  = it[10];
      jumper_sel = it[11];
      cpu_addr   = 15'((it * 7919) ^ (it << 5));
      cpu_rom_rd = it[0] ^ it[5];
      base_prg   = 5'((it * 13) ^ (it >> 3));
      base_chr   = 8'((it * 37) ^ (it >> 2));
      ppu_addr   = 13'(it * 101 + (it >> 4));
      chr_bank   = 4'((it >> 1) ^ (it >> 7));
      rom_data   = 8'(it * 29 + 7);
      jumper     = 2'(it >> 3);
      #1;
      check_all();
    end
    // R10: base CHR bits have no effect in fixed CHR mode
    @(negedge clk);
    chr_fixed = 1; chr_bank = 4'ha; ppu_addr = 13'h1234; outer_cfg = 8'h80; base_chr = 8'h00;
    #1; chk("R10 base ignored a", chr_addr % 131072, 32'h15234);
    base_chr = 8'h7f;
    #1; chk("R10 base ignored b", chr_addr % 131072, 32'h15234);
    // R12: outputs follow a change with no clock edge in between
    @(negedge clk);
    prg_mode = 3; cpu_addr = 15'h6abc; jumper_sel = 1; cpu_rom_rd = 1; jumper = 2'b10; rom_data = 8'hff;
    #1; chk("R12 prg settle", prg_addr % 32768, 32'h6abc);
    chk("R12 data settle", cpu_data, 2);
    cpu_rom_rd = 0;
    #1; chk("R12 data revert", cpu_data, 32'hff);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog act=timeout exp=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule